// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the memory-mapped control core of a simple display controller. A 32-bit register interface on a word-aligned address bus reaches six registers, each owning a 16-byte slot. Inside a slot the word sub-offset selects how a write is applied: a plain store, or an OR, AND-NOT or XOR of the data into the stored value. Only the two control registers accept the three modifying forms.

The block keeps the run bit, the pixel word-length field, the frame-done flag with its interrupt enable, the transfer size, and the current and next frame buffer addresses. While the controller runs and no frame-done is pending, a frame-period counter counts clock cycles. When it expires it raises the flag. A level interrupt follows the flag gated by its enable. Writing the next-buffer register promotes its value to the current buffer at once and signals frame done. The alternate next-buffer register only signals frame done. The fetch logic downstream takes the run bit, word length, transfer count and current buffer from the outputs, and a one-cycle invalidate pulse tells it to restart from a fresh frame.

Top module: `dispc_regs_top`

## Requirements
- R1: After reset every register reads zero except control 1 (offset 0x10), which reads 0x000F0000. irq and invalidate are 0.
- R2: A write at sub-offset 0x0 of a defined slot (0x00, 0x10, 0x30, 0x40, 0x50, 0x230) stores the full 32-bit data. A read at any sub-offset of a slot returns the stored value. Undefined slots read zero, and writes to them change nothing.
- R3: For control (0x00) and control 1 (0x10), a write at sub-offset 0x4 ORs the data in, 0x8 clears the bits set in the data, and 0xC XORs the data in.
- R4: Writes at sub-offsets 0x4, 0x8 or 0xC of any slot other than the two control registers are ignored. They change no register and do not promote the next buffer.
- R5: irq is a level equal to control 1 bit 13 (enable) AND control 1 bit 9 (frame-done flag).
- R6: While control bit 0 (RUN) is 1 and the flag is 0, the flag becomes 1 exactly FRAME_CYCLES clock cycles after the clock edge that made the counter eligible to run. While RUN is 0 the counter never sets the flag.
- R7: Clearing the flag while RUN is 1 restarts a full frame period. Clearing RUN before expiry stops the counter, and no flag follows.
- R8: A plain write to the next-buffer register (0x50) stores the data there and copies it into the current-buffer register (0x40). The same edge sets the flag.
- R9: A plain write to the alternate next-buffer register (0x230) stores the data and sets the flag. The current buffer is left unchanged.
- R10: invalidate is high for the single cycle after a plain write to transfer count (0x30), current buffer (0x40) or next buffer (0x50).
- R11: runOut equals control bit 0 and wordLenOut equals control bits 9:8. xferCount and curBuf equal the stored transfer-count and current-buffer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busWordAddr | input | ADDR_W-2 | Word address; bits [1:0] select sub-offset, upper bits select slot |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed slot, combinational |
| irq | output | 1 | Level frame-done interrupt |
| invalidate | output | 1 | One-cycle pulse: restart fetch from a fresh frame |
| runOut | output | 1 | Run bit |
| wordLenOut | output | 2 | Pixel word-length field |
| xferCount | output | 32 | Transfer-count register |
| curBuf | output | 32 | Current-buffer address |

## Verification
The bench builds the block with FRAME_CYCLES set to 20, so a frame expiry, a restart after the flag is cleared, and a stop before expiry each take only tens of cycles. That short period makes it possible to check the exact cycle on which the flag rises. ADDR_W stays at its default of 14, which reaches the 0x230 slot and also slots far past it, so the bench exercises reads and writes of undefined space.

// File: rtl/dispc_pkg.sv
package dispc_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } wrOp_e;

  // slot index = byte offset >> 4
  localparam int SLOT_CTRL  = 0;
  localparam int SLOT_CTRL1 = 1;
  localparam int SLOT_XFER  = 3;
  localparam int SLOT_CUR   = 4;
  localparam int SLOT_NEXT  = 5;
  localparam int SLOT_ALT   = 35;

  localparam int BIT_RUN      = 0;
  localparam int BIT_FLAG     = 9;
  localparam int BIT_IRQ_EN   = 13;
  localparam logic [31:0] CTRL1_RESET = 32'h000F_0000;

  typedef struct packed {
    logic  ldCtrl;
    logic  ldCtrl1;
    logic  ldXfer;
    logic  ldCur;
    logic  ldNext;
    logic  ldAlt;
    logic  frameExpire;
    wrOp_e op;
  } regStrobe_t;

  function automatic logic [31:0] applyOp(logic [31:0] old, logic [31:0] d, wrOp_e op);
    case (op)
      OP_SET:  return old | d;
      OP_CLR:  return old & ~d;
      OP_TOG:  return old ^ d;
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/dispc_ctrl.sv
module dispc_ctrl
  import dispc_pkg::*;
#(
  parameter int SLOT_W       = 10,
  parameter int FRAME_CYCLES = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] slot,
  input  wrOp_e             op,
  input  logic              runBit,
  input  logic              flagBit,
  output regStrobe_t        strb
);
  localparam int CNT_W = $clog2(FRAME_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_CYCLES - 1);

  logic [CNT_W-1:0] frameCnt;
  logic counting;
  logic plainWr;

  assign counting = runBit && !flagBit;
  assign plainWr  = wrEn && (op == OP_WRITE);

  always_comb begin
    strb             = '0;
    strb.op          = op;
    strb.ldCtrl      = wrEn && (slot == SLOT_W'(SLOT_CTRL));
    strb.ldCtrl1     = wrEn && (slot == SLOT_W'(SLOT_CTRL1));
    strb.ldXfer      = plainWr && (slot == SLOT_W'(SLOT_XFER));
    strb.ldCur       = plainWr && (slot == SLOT_W'(SLOT_CUR));
    strb.ldNext      = plainWr && (slot == SLOT_W'(SLOT_NEXT));
    strb.ldAlt       = plainWr && (slot == SLOT_W'(SLOT_ALT));
    strb.frameExpire = counting && (frameCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      frameCnt <= '0;
    else if (!counting || frameCnt == CNT_LAST)
      frameCnt <= '0;
    else
      frameCnt <= frameCnt + 1'b1;
  end
endmodule

// File: rtl/dispc_regfile.sv
module dispc_regfile
  import dispc_pkg::*;
#(
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [31:0]       wrData,
  input  logic [SLOT_W-1:0] rdSlot,
  output logic [31:0]       rdData,
  output logic [31:0]       ctrlReg,
  output logic [31:0]       ctrl1Reg,
  output logic [31:0]       xferReg,
  output logic [31:0]       curReg,
  output logic              invalPulse
);
  logic [31:0] nextReg;
  logic [31:0] altReg;
  logic [31:0] ctrl1Nxt;

  always_comb begin
    ctrl1Nxt = strb.ldCtrl1 ? applyOp(ctrl1Reg, wrData, strb.op) : ctrl1Reg;
    if (strb.ldNext || strb.ldAlt || strb.frameExpire)
      ctrl1Nxt[BIT_FLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      ctrl1Reg   <= CTRL1_RESET;
      xferReg    <= '0;
      curReg     <= '0;
      nextReg    <= '0;
      altReg     <= '0;
      invalPulse <= 1'b0;
    end else begin
      if (strb.ldCtrl) ctrlReg <= applyOp(ctrlReg, wrData, strb.op);
      ctrl1Reg <= ctrl1Nxt;
      if (strb.ldXfer) xferReg <= wrData;
      if (strb.ldNext || strb.ldCur) curReg <= wrData;
      if (strb.ldNext) nextReg <= wrData;
      if (strb.ldAlt) altReg <= wrData;
      invalPulse <= strb.ldXfer || strb.ldCur || strb.ldNext;
    end
  end

  always_comb begin
    case (rdSlot)
      SLOT_W'(SLOT_CTRL):  rdData = ctrlReg;
      SLOT_W'(SLOT_CTRL1): rdData = ctrl1Reg;
      SLOT_W'(SLOT_XFER):  rdData = xferReg;
      SLOT_W'(SLOT_CUR):   rdData = curReg;
      SLOT_W'(SLOT_NEXT):  rdData = nextReg;
      SLOT_W'(SLOT_ALT):   rdData = altReg;
      default:             rdData = '0;
    endcase
  end
endmodule

// File: rtl/dispc_regs_top.sv
module dispc_regs_top
  import dispc_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int FRAME_CYCLES = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:2] busWordAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic              invalidate,
  output logic              runOut,
  output logic [1:0]        wordLenOut,
  output logic [31:0]       xferCount,
  output logic [31:0]       curBuf
);
  localparam int SLOT_W = ADDR_W - 4;

  regStrobe_t        strb;
  logic [SLOT_W-1:0] slot;
  wrOp_e             op;
  logic [31:0]       ctrlReg;
  logic [31:0]       ctrl1Reg;
  logic              frameFlag;

  assign slot      = busWordAddr[ADDR_W-1:4];
  assign op        = wrOp_e'(busWordAddr[3:2]);
  assign frameFlag = ctrl1Reg[BIT_FLAG];

  dispc_ctrl #(.SLOT_W(SLOT_W), .FRAME_CYCLES(FRAME_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .slot(slot), .op(op),
    .runBit(ctrlReg[BIT_RUN]), .flagBit(frameFlag), .strb(strb)
  );

  dispc_regfile #(.SLOT_W(SLOT_W)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .rdSlot(slot), .rdData(busRdData), .ctrlReg(ctrlReg),
    .ctrl1Reg(ctrl1Reg), .xferReg(xferCount), .curReg(curBuf),
    .invalPulse(invalidate)
  );

  assign irq        = ctrl1Reg[BIT_IRQ_EN] && frameFlag;
  assign runOut     = ctrlReg[BIT_RUN];
  assign wordLenOut = ctrlReg[9:8];
endmodule

// File: rtl/dispc_regs_chk.sv
module dispc_regs_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:2] busWordAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       xferCount,
  input logic [31:0]       curBuf,
  input logic              frameFlag,
  input logic              runOut,
  input logic              irq,
  input logic              invalidate
);
  localparam int AW = ADDR_W - 2;
  logic [AW-1:0] wa;
  assign wa = busWordAddr;

  logic xferAlias, nextPlain, altPlain, ctrl1PlainNoEn;
  assign xferAlias = busWrEn && (wa[AW-1:2] == (AW-2)'(3)) && (wa[1:0] != 2'd0);
  assign nextPlain = busWrEn && (wa == AW'(12'h50 >> 2));
  assign altPlain  = busWrEn && (wa == AW'(12'h230 >> 2));
  assign ctrl1PlainNoEn = busWrEn && (wa == AW'(12'h10 >> 2)) && !busWrData[13];

  assert_alias_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferAlias |=> $stable(xferCount));
  assert_next_promote_R8: assert property (@(posedge clk) disable iff (!rstN)
    nextPlain |=> (curBuf == $past(busWrData)) && frameFlag);
  assert_alt_keeps_cur_R9: assert property (@(posedge clk) disable iff (!rstN)
    altPlain |=> $stable(curBuf) && frameFlag);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl1PlainNoEn |=> !irq);
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameFlag) |-> ($past(runOut) || $past(busWrEn)));
  assert_inval_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |-> $past(busWrEn));
endmodule

bind dispc_regs_top dispc_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
  .busWrData(busWrData), .xferCount(xferCount), .curBuf(curBuf),
  .frameFlag(frameFlag), .runOut(runOut), .irq(irq), .invalidate(invalidate)
);

// File: tb/dispc_regs_top_tb_top.sv
`timescale 1ns/1ps
module dispc_regs_top_tb_top;
  localparam int ADDR_W = 14;
  localparam int PERIOD = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [ADDR_W-1:2] busWordAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq, invalidate, runOut;
  logic [1:0] wordLenOut;
  logic [31:0] xferCount, curBuf;

  int total = 0;
  int bad = 0;
  logic lastInval;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dispc_regs_top #(.ADDR_W(ADDR_W), .FRAME_CYCLES(PERIOD)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .invalidate(invalidate), .runOut(runOut), .wordLenOut(wordLenOut),
    .xferCount(xferCount), .curBuf(curBuf)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [13:0] addr, logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busWordAddr = addr[13:2]; busWrData = d;
    @(negedge clk);
    lastInval = invalidate;
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [13:0] addr, output logic [31:0] d);
    busWordAddr = addr[13:2];
    #0.5;
    d = busRdData;
  endtask

  task automatic t_reset;
    rd(14'h000, rv); check("R1 ctrl", rv, 0);
    rd(14'h010, rv); check("R1 ctrl1", rv, 32'h000F0000);
    rd(14'h030, rv); check("R1 xfer", rv, 0);
    rd(14'h040, rv); check("R1 cur", rv, 0);
    rd(14'h050, rv); check("R1 next", rv, 0);
    rd(14'h230, rv); check("R1 alt", rv, 0);
    check("R1 irq", irq, 0);
    check("R1 inval", invalidate, 0);
  endtask

  task automatic t_plain;
    wr(14'h030, 32'h00F0_0140);
    check("R10 inval xfer", lastInval, 1);
    @(negedge clk); check("R10 inval one cycle", invalidate, 0);
    rd(14'h03C, rv); check("R2 xfer read sub C", rv, 32'h00F0_0140);
    check("R11 xferCount", xferCount, 32'h00F0_0140);
    wr(14'h040, 32'h8000_1000);
    check("R10 inval cur", lastInval, 1);
    rd(14'h044, rv); check("R2 cur read sub 4", rv, 32'h8000_1000);
    check("R11 curBuf", curBuf, 32'h8000_1000);
    wr(14'h010, 32'h000F_0000);
    check("R10 no inval ctrl1", lastInval, 0);
  endtask

  task automatic t_alias;
    wr(14'h000, 32'h0000_0200);
    wr(14'h004, 32'h0000_0100); rd(14'h000, rv); check("R3 ctrl set", rv, 32'h300);
    wr(14'h008, 32'h0000_0200); rd(14'h000, rv); check("R3 ctrl clr", rv, 32'h100);
    wr(14'h00C, 32'h0000_0300); rd(14'h000, rv); check("R3 ctrl tog", rv, 32'h200);
    check("R11 wordLen", wordLenOut, 2'd2);
    check("R11 run off", runOut, 0);
    wr(14'h014, 32'h0000_2000); rd(14'h010, rv); check("R3 ctrl1 set", rv, 32'h000F2000);
    wr(14'h018, 32'h000F_0000); rd(14'h010, rv); check("R3 ctrl1 clr", rv, 32'h00002000);
    wr(14'h01C, 32'h000F_0000); rd(14'h010, rv); check("R3 ctrl1 tog", rv, 32'h000F2000);
  endtask

  task automatic t_alias_ignored;
    wr(14'h034, 32'hFFFF_FFFF); rd(14'h030, rv); check("R4 xfer set ignored", rv, 32'h00F0_0140);
    wr(14'h038, 32'hFFFF_FFFF); rd(14'h030, rv); check("R4 xfer clr ignored", rv, 32'h00F0_0140);
    wr(14'h04C, 32'h1234_5678); rd(14'h040, rv); check("R4 cur tog ignored", rv, 32'h8000_1000);
    wr(14'h054, 32'h5555_0000);
    rd(14'h040, rv); check("R4 next alias no promote", rv, 32'h8000_1000);
    rd(14'h050, rv); check("R4 next alias no store", rv, 0);
    rd(14'h010, rv); check("R4 next alias no flag", rv[9], 0);
  endtask

  task automatic t_irq_alt;
    check("R5 irq off no flag", irq, 0);
    wr(14'h230, 32'h0000_00AA);
    rd(14'h230, rv); check("R9 alt stored", rv, 32'hAA);
    rd(14'h040, rv); check("R9 cur unchanged", rv, 32'h8000_1000);
    rd(14'h010, rv); check("R9 flag set", rv[9], 1);
    check("R5 irq on", irq, 1);
    wr(14'h018, 32'h0000_2000);
    check("R5 irq masked", irq, 0);
    rd(14'h010, rv); check("R5 flag kept", rv[9], 1);
    wr(14'h014, 32'h0000_2000);
    check("R5 irq re-enabled", irq, 1);
    wr(14'h018, 32'h0000_0200);
    check("R5 irq after clear", irq, 0);
  endtask

  task automatic t_frame;
    wr(14'h000, 32'h0000_0001);
    check("R11 run on", runOut, 1);
    repeat (PERIOD - 1) @(negedge clk);
    check("R6 no flag before period", irq, 0);
    @(negedge clk);
    check("R6 flag at period", irq, 1);
    repeat (3 * PERIOD) @(negedge clk);
    check("R6 flag holds", irq, 1);
    wr(14'h018, 32'h0000_0200);
    check("R7 flag cleared", irq, 0);
    repeat (PERIOD - 1) @(negedge clk);
    check("R7 no flag before restart period", irq, 0);
    @(negedge clk);
    check("R7 flag after restart period", irq, 1);
    wr(14'h018, 32'h0000_0200);
    wr(14'h008, 32'h0000_0001);
    repeat (3 * PERIOD) @(negedge clk);
    rd(14'h010, rv); check("R7 stopped no flag", rv[9], 0);
    check("R6 idle no irq", irq, 0);
  endtask

  task automatic t_next;
    wr(14'h050, 32'hABCD_0000);
    check("R10 inval next", lastInval, 1);
    rd(14'h040, rv); check("R8 promoted", rv, 32'hABCD_0000);
    rd(14'h050, rv); check("R8 next stored", rv, 32'hABCD_0000);
    rd(14'h010, rv); check("R8 flag set", rv[9], 1);
    check("R8 irq", irq, 1);
  endtask

  task automatic t_undef;
    wr(14'h060, 32'hDEAD_BEEF);
    rd(14'h060, rv); check("R2 undefined slot", rv, 0);
    wr(14'h3000, 32'hDEAD_BEEF);
    rd(14'h3000, rv); check("R2 far slot", rv, 0);
    rd(14'h030, rv); check("R2 neighbours intact", rv, 32'h00F0_0140);
    rd(14'h020, rv); check("R2 gap slot", rv, 0);
  endtask

  initial begin : watchdog
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lastInval = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_alias();
    t_alias_ignored();
    t_irq_alt();
    t_frame();
    t_next();
    t_undef();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule